// File: doc/BRIEF.md
# Bit-reflected CRC-32 frame check appender

This block sits in a transmit datapath and appends a 32-bit frame check sequence to each outgoing frame body. Body octets arrive on a valid/ready byte stream with a first-octet marker and a last marker. They pass straight through to the output stream. The CRC is updated in the same cycle each octet is accepted. One cycle after the final body octet is accepted, four check octets follow on the same output, with backpressure honoured throughout.

The line serializer downstream sends every octet bit 0 first. The checksum is therefore computed in that order: bit 0 of each octet enters the remainder first, using the reflected form of the standard CRC-32 polynomial. The check octets are ordered so that the complemented remainder also leaves bit 0 first. Feeding octets bit 7 first gives a value that looks plausible but is wrong, and this block does not do that.

A frame may end with an empty beat, which carries no octet. This lets a zero-length body still be closed with a valid check sequence.

Top module: `fcsgen_append`

## Requirements
- R1: The remainder is preset to 0xFFFFFFFF when an octet marked first is accepted. Each accepted body octet is folded in bit 0 first, bit 7 last, using the reflected polynomial 0xEDB88320. For the body "123456789" the check value is 0xCBF43926, not the bit-7-first value.
- R2: The check value is the bitwise complement of the final remainder.
- R3: The check octets leave in order of significance, least significant first: octet k is bits 8k+7..8k of the check value. The four octets of 0xCBF43926 are therefore 0x26, 0x39, 0xF4, 0xCB.
- R4: While a body is flowing, every non-empty input beat appears unchanged on the output in the same cycle, and in_ready equals out_ready.
- R5: The first check octet is presented in the cycle after the last body beat is accepted. Exactly four check octets follow, and out_last is high on the fourth only.
- R6: While out_valid is high and out_ready is low, out_valid, out_data and out_last hold their values.
- R7: in_ready is low from the acceptance of a last beat until the fourth check octet has been taken.
- R8: A beat with in_empty=1 (legal only with in_last=1) is consumed without producing an output octet. If that beat is also marked first, the body is empty and the check octets are 0x00, 0x00, 0x00, 0x00.
- R9: After reset the block is between frames: out_valid is low while in_valid is low, and in_ready follows out_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Input beat taken at this edge when in_valid is high |
| in_data | input | 8 | Body octet |
| in_first | input | 1 | Beat opens a frame; presets the remainder |
| in_last | input | 1 | Beat closes the body |
| in_empty | input | 1 | Beat carries no octet (only with in_last) |
| out_valid | output | 1 | Output octet present |
| out_ready | input | 1 | Downstream takes the octet |
| out_data | output | 8 | Body octet or check octet |
| out_last | output | 1 | Final check octet of the frame |

## Verification
The checker assumes that the upstream source obeys valid/ready. A presented beat keeps its data and markers until it is taken, and in_empty is raised only together with in_last. Under that assumption, a stalled body octet on the output is stable. The bench drives every beat from a single task that holds all fields until in_ready is seen high. It raises in_empty only on closing beats, so the stimulus stays within these assumptions while downstream stalls are inserted at random.

// File: rtl/fcsgen_pkg.sv
package fcsgen_pkg;
  localparam int unsigned OCTET_W   = 8;
  localparam int unsigned SUM_W     = 32;
  localparam logic [SUM_W-1:0] POLY_REFL  = 32'hEDB88320;
  localparam logic [SUM_W-1:0] SUM_PRESET = 32'hFFFFFFFF;

  typedef enum logic {
    PH_BODY  = 1'b0,
    PH_TRAIL = 1'b1
  } phase_e;
endpackage

// File: rtl/fcsgen_step.sv
// Folds one octet into a reflected remainder, bit 0 of the octet first.
module fcsgen_step #(
  parameter int unsigned SUM_W   = fcsgen_pkg::SUM_W,
  parameter int unsigned OCTET_W = fcsgen_pkg::OCTET_W,
  parameter logic [SUM_W-1:0] POLY = fcsgen_pkg::POLY_REFL
) (
  input  logic [SUM_W-1:0]   rem_in,
  input  logic [OCTET_W-1:0] octet,
  output logic [SUM_W-1:0]   rem_out
);
  always_comb begin
    rem_out = rem_in;
    for (int b = 0; b < OCTET_W; b++) begin
      if (rem_out[0] ^ octet[b]) rem_out = (rem_out >> 1) ^ POLY;
      else                       rem_out = rem_out >> 1;
    end
  end
endmodule

// File: rtl/fcsgen_acc.sv
// Remainder register with preset on the opening beat.
module fcsgen_acc #(
  parameter int unsigned SUM_W   = fcsgen_pkg::SUM_W,
  parameter int unsigned OCTET_W = fcsgen_pkg::OCTET_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic               take,
  input  logic [OCTET_W-1:0] octet,
  output logic [SUM_W-1:0]   rem
);
  logic [SUM_W-1:0] rem_q, rem_d, base, stepped;
  logic             rem_en;

  assign base = restart ? fcsgen_pkg::SUM_PRESET : rem_q;

  fcsgen_step #(.SUM_W(SUM_W), .OCTET_W(OCTET_W)) u_step (
    .rem_in (base),
    .octet  (octet),
    .rem_out(stepped)
  );

  always_comb begin
    rem_en = take | restart;
    rem_d  = take ? stepped : base;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rem_q <= fcsgen_pkg::SUM_PRESET;
    else if (rem_en) rem_q <= rem_d;
  end

  assign rem = rem_q;
endmodule

// File: rtl/fcsgen_seq.sv
// Body / trailer sequencing and trailer octet index.
module fcsgen_seq #(
  parameter int unsigned LANES = 4,
  localparam int unsigned IDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_last,
  input  logic             in_empty,
  input  logic             out_ready,
  output logic             in_ready,
  output logic             trail_on,
  output logic [IDX_W-1:0] trail_idx,
  output logic             trail_end
);
  import fcsgen_pkg::*;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LANES - 1);

  phase_e           phase_q, phase_d;
  logic             phase_en;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             idx_en;

  assign trail_on  = (phase_q == PH_TRAIL);
  assign trail_idx = idx_q;
  assign trail_end = trail_on && (idx_q == LAST_IDX);
  assign in_ready  = !trail_on && (out_ready || in_empty);

  always_comb begin
    phase_d  = phase_q;
    phase_en = 1'b0;
    idx_d    = idx_q;
    idx_en   = 1'b0;
    unique case (phase_q)
      PH_BODY: begin
        if (in_valid && in_ready && in_last) begin
          phase_d  = PH_TRAIL;
          phase_en = 1'b1;
          idx_d    = '0;
          idx_en   = 1'b1;
        end
      end
      PH_TRAIL: begin
        if (out_ready) begin
          idx_en = 1'b1;
          if (trail_end) begin
            phase_d  = PH_BODY;
            phase_en = 1'b1;
            idx_d    = '0;
          end else begin
            idx_d = idx_q + IDX_W'(1);
          end
        end
      end
      default: begin
        phase_d  = PH_BODY;
        phase_en = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        phase_q <= PH_BODY;
    else if (phase_en) phase_q <= phase_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end
endmodule

// File: rtl/fcsgen_append.sv
module fcsgen_append #(
  parameter int unsigned OCTET_W = fcsgen_pkg::OCTET_W,
  parameter int unsigned SUM_W   = fcsgen_pkg::SUM_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [OCTET_W-1:0] in_data,
  input  logic               in_first,
  input  logic               in_last,
  input  logic               in_empty,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [OCTET_W-1:0] out_data,
  output logic               out_last
);
  localparam int unsigned LANES = SUM_W / OCTET_W;
  localparam int unsigned IDX_W = (LANES > 1) ? $clog2(LANES) : 1;

  logic                            accept;
  logic [SUM_W-1:0]                rem;
  logic                            trail_on, trail_end;
  logic [IDX_W-1:0]                trail_idx;
  logic [LANES-1:0][OCTET_W-1:0]   lane;

  assign accept = in_valid && in_ready;

  fcsgen_seq #(.LANES(LANES)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_last  (in_last),
    .in_empty (in_empty),
    .out_ready(out_ready),
    .in_ready (in_ready),
    .trail_on (trail_on),
    .trail_idx(trail_idx),
    .trail_end(trail_end)
  );

  fcsgen_acc #(.SUM_W(SUM_W), .OCTET_W(OCTET_W)) u_acc (
    .clk    (clk),
    .rst_n  (rst_n),
    .restart(accept && in_first),
    .take   (accept && !in_empty),
    .octet  (in_data),
    .rem    (rem)
  );

  // Complemented remainder, least significant octet leaves first.
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane[k] = ~rem[k*OCTET_W +: OCTET_W];
  end

  assign out_valid = trail_on ? 1'b1 : (in_valid && !in_empty);
  assign out_data  = trail_on ? lane[trail_idx] : in_data;
  assign out_last  = trail_end;
endmodule

// File: rtl/fcsgen_checker.sv
module fcsgen_checker #(
  parameter int unsigned OCTET_W = 8,
  parameter int unsigned LANES   = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic [OCTET_W-1:0] in_data,
  input logic               in_last,
  input logic               in_empty,
  input logic               out_valid,
  input logic               out_ready,
  input logic [OCTET_W-1:0] out_data,
  input logic               out_last
);
  logic       armed;
  logic [7:0] beats;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      beats <= '0;
    end else if (in_valid && in_ready && in_last) begin
      armed <= 1'b1;
      beats <= '0;
    end else if (armed && out_valid && out_ready) begin
      beats <= beats + 8'd1;
      if (out_last) armed <= 1'b0;
    end
  end

  // R4
  body_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_empty) |-> (out_valid && out_ready && out_data == in_data));

  // R5
  trail_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && out_valid) |-> (out_last == (beats == 8'(LANES - 1))));

  // R5
  trail_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_last) |=> (out_valid && !out_last));

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  // R7
  trail_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> !in_ready);

  // R8
  empty_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_empty) |-> !out_valid);
endmodule

bind fcsgen_append fcsgen_checker #(.OCTET_W(OCTET_W), .LANES(SUM_W / OCTET_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_data  (in_data),
  .in_last  (in_last),
  .in_empty (in_empty),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_data (out_data),
  .out_last (out_last)
);

// File: tb/fcsgen_append_bench.sv
`timescale 1ns/1ps
module fcsgen_append_bench;
  typedef struct {
    logic [7:0] d;
    logic       l;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid, in_first, in_last, in_empty, out_ready;
  logic [7:0] in_data;
  logic       in_ready, out_valid, out_last;
  logic [7:0] out_data;

  int unsigned n_chk  = 0;
  int unsigned n_fail = 0;
  bit          stall_on = 1'b0;
  logic [31:0] cap;
  exp_t        sb[$];

  always #5 clk = ~clk;

  fcsgen_append u_fcsgen_append (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_first(in_first), .in_last(in_last), .in_empty(in_empty),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last)
  );

  // Reference: bit 0 first, reflected polynomial, complemented result.
  function automatic logic [31:0] crc_lsb(input byte unsigned b[]);
    logic [31:0] r = 32'hFFFFFFFF;
    foreach (b[i]) begin
      for (int j = 0; j < 8; j++) begin
        logic fb;
        fb = r[0] ^ b[i][j];
        r  = r >> 1;
        if (fb) r = r ^ 32'hEDB88320;
      end
    end
    return ~r;
  endfunction

  // The mistaken ordering: bit 7 first, normal polynomial.
  function automatic logic [31:0] crc_msb(input byte unsigned b[]);
    logic [31:0] r = 32'hFFFFFFFF;
    foreach (b[i]) begin
      for (int j = 7; j >= 0; j--) begin
        logic fb;
        fb = r[31] ^ b[i][j];
        r  = r << 1;
        if (fb) r = r ^ 32'h04C11DB7;
      end
    end
    return ~r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic beat(input logic [7:0] d, input bit f, input bit l, input bit e);
    in_valid = 1'b1; in_data = d; in_first = f; in_last = l; in_empty = e;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
    in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0; in_empty = 1'b0;
  endtask

  task automatic send(input byte unsigned body[], input bit empty_tail, input string ftag);
    logic [31:0] f;
    int n;
    n = body.size();
    f = crc_lsb(body);
    foreach (body[i]) sb.push_back('{body[i], 1'b0, "R4 body"});
    for (int k = 0; k < 4; k++) sb.push_back('{f[8*k +: 8], k == 3, ftag});
    foreach (body[i]) beat(body[i], i == 0, (i == n - 1) && !empty_tail, 1'b0);
    if (n == 0 || empty_tail) beat(8'h00, n == 0, 1'b1, 1'b1);
    @(negedge clk);
    check(!in_ready && out_valid, "R7/R5 trailer starts and input blocked", {30'd0, in_ready, out_valid}, 32'h1);
    while (sb.size() != 0) @(negedge clk);
    check(cap == f, "R3 check octet order", cap, f);
  endtask

  // Scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && out_valid && out_ready) begin
        cap = {out_data, cap[31:8]};
        if (sb.size() == 0) begin
          check(1'b0, "R4 unexpected octet", {24'd0, out_data}, 32'h0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(out_data == e.d && out_last == e.l, e.tag,
                {23'd0, out_last, out_data}, {23'd0, e.l, e.d});
        end
      end
    end
  end

  // Downstream readiness
  initial begin
    out_ready = 1'b1;
    forever begin
      @(posedge clk); #1;
      out_ready = stall_on ? ($urandom_range(3) != 0) : 1'b1;
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    byte unsigned s[];
    byte unsigned z[];
    string txt;
    in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0; in_empty = 1'b0; in_data = 8'h00;
    rst_n = 1'b0;
    cap = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!out_valid, "R9 reset out_valid", {31'd0, out_valid}, 32'h0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && in_ready, "R9 idle after reset", {30'd0, out_valid, in_ready}, 32'h1);

    // R1 model sanity against the published check value
    txt = "123456789";
    s = new[txt.len()];
    foreach (s[i]) s[i] = txt[i];
    check(crc_lsb(s) == 32'hCBF43926, "R1 reference model", crc_lsb(s), 32'hCBF43926);

    @(posedge clk); #1;
    send(s, 1'b0, "R1/R2 check octet");
    check(cap == 32'hCBF43926, "R1 123456789 value", cap, 32'hCBF43926);
    check(cap != crc_msb(s), "R1 not bit-7-first value", cap, 32'hCBF43926);
    check({cap[7:0], cap[15:8], cap[23:16], cap[31:24]} == 32'h2639F4CB, "R3 octet sequence",
          {cap[7:0], cap[15:8], cap[23:16], cap[31:24]}, 32'h2639F4CB);

    // R8 zero-length body
    z = new[0];
    send(z, 1'b0, "R8 empty body");
    check(cap == 32'h0, "R8 empty value", cap, 32'h0);

    // single zero octet
    s = new[1]; s[0] = 8'h00;
    send(s, 1'b0, "R2 single octet");
    check(cap == 32'hD202EF8D, "R2 single zero octet", cap, 32'hD202EF8D);

    // 96-octet body (24 header + 72 payload) under stalls
    stall_on = 1'b1;
    s = new[96];
    foreach (s[i]) s[i] = (i < 24) ? byte'(8'h08 + 8'(i * 17)) : byte'(8'h20 + 8'(i % 90));
    send(s, 1'b0, "R6 long frame under stall");
    check(cap != crc_msb(s), "R1 long frame not bit-7-first", cap, crc_lsb(s));

    // body closed by an empty beat, with stalls
    s = new[5];
    foreach (s[i]) s[i] = byte'(8'hA5 ^ 8'(i * 3));
    send(s, 1'b1, "R8 empty closing beat");

    // back-to-back random frames
    for (int fr = 0; fr < 20; fr++) begin
      s = new[$urandom_range(1, 40)];
      foreach (s[i]) s[i] = byte'($urandom_range(255));
      send(s, fr[0], "R2 random frame");
    end

    stall_on = 1'b0;
    repeat (4) @(negedge clk);
    check(sb.size() == 0 && !out_valid, "R5 no extra octets", {31'd0, out_valid}, 32'h0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule